// File: doc/BRIEF.md
# Entropy FIFO refill sequencer

This block sequences a random-number source and keeps a small circular FIFO of 32-bit words topped up. A free-running LFSR stands in for the noise source. Once enabled, the controller runs a startup interval. It then produces words in batches and writes them into the FIFO until the FIFO is full.

When the FIFO is full the controller waits with the oscillator on. If no read arrives before a programmable timeout, it turns the oscillator off. Software reads pop one word at a time. A pop that leaves the level below a programmable low-water mark restarts generation. From the oscillator-on idle state this goes straight to filling. From the oscillator-off idle state it first repeats the startup interval.

Batch timing depends on the conditioning mode. In bypass mode the controller produces one word per 32-bit interval. With conditioning on it produces four words per group of 128-bit blocks. Both intervals are scaled by a clock divider.

Top module: `rng_refill_seq`

## Requirements
- R1: `state_o` shows the controller state with these codes: 0 reset, 1 startup, 2 idle with oscillator on, 3 idle with oscillator off, 4 filling, 5 error. Code 5 is reserved, and no path in this block enters it.
- R2: A rising edge of `en_i` seen in the reset state enters startup. Startup lasts `init_wait_i + STARTUP_TEST` cycles (STARTUP_TEST defaults to 16), and the controller then enters filling.
- R3: With `bypass_i` = 1, let D = 32*(`clkdiv_i`+1). The k-th word of a fill (k = 1, 2, ...) raises `level_o` k*D+1 cycles after `state_o` first reads 4.
- R4: With `bypass_i` = 0, let D = 128*NB*(`clkdiv_i`+1), where NB is `nblk_i` and a value of 0 counts as 1. Batch j (j = 1, 2, ...) writes four words, which raise `level_o` at j*D+1, j*D+2, j*D+3 and j*D+4 cycles after filling starts.
- R5: Words are written only while the FIFO is not full, and any words still pending in a batch at that point are dropped. Once the FIFO is full the controller enters idle-on, and `level_o` never exceeds DEPTH (default 8).
- R6: Idle-on lasts max(`off_tmo_i`,1) cycles without a triggering pop and then moves to idle-off. Idle-off holds until a pop triggers a refill.
- R7: A pop on a non-empty FIFO lowers `level_o` by one and returns the oldest word on `pop_data_o` one cycle later. If the level after the pop is below (`thresh_i`+1)*4, idle-on goes to filling and idle-off goes to startup. Otherwise the state is unchanged.
- R8: A pop on an empty FIFO leaves `level_o` at 0 and the pointers where they are, and returns the word stored at the read pointer.
- R9: A write and a pop in the same cycle leave `level_o` unchanged.
- R10: `soft_rst_i` clears the level and both pointers, drops pending words and forces state 0. The block stays in reset until `en_i` falls and rises again.
- R11: While `en_i` is low the state is 0 from the next cycle on, and the FIFO contents and level are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable level; a rising edge starts the sequencer |
| soft_rst_i | input | 1 | Soft reset strobe |
| bypass_i | input | 1 | 1 = conditioning bypassed (one word per batch) |
| nblk_i | input | NB_W | Number of 128-bit blocks per conditioned batch |
| clkdiv_i | input | DIV_W | Clock divider; intervals scale by value+1 |
| init_wait_i | input | CNT_W | Startup wait count |
| off_tmo_i | input | CNT_W | Oscillator switch-off timeout |
| thresh_i | input | THR_W | Low-water mark setting, mark = (value+1)*4 |
| pop_i | input | 1 | FIFO pop strobe |
| pop_data_o | output | DATA_W | Word returned by the last pop |
| level_o | output | LVL_W | FIFO fill level |
| state_o | output | 3 | State code |

## Verification
A batch write and a software pop can fall in the same cycle. A refill trigger from a pop can also meet a state transition. The bench times its pop so that the pop and the second write of a bypass fill land on the same clock edge. It then expects the level to stay at its previous value, and the next write to raise it by one at the cycle computed from the divider. The bench also drains a full FIFO during startup and then pops it empty. The empty pop must return the first word read in that drain, because the read pointer has wrapped back to the same slot. In conditioned mode the bench triggers a refill from a partly drained FIFO. The second batch then overruns the free space, and the bench expects the level to stop at DEPTH with the controller back in idle-on.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_STARTUP  = 3'd1,
    ST_IDLE_ON  = 3'd2,
    ST_IDLE_OFF = 3'd3,
    ST_FILL     = 3'd4,
    ST_ERROR    = 3'd5
  } seq_state_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C,
  parameter logic [W-1:0] TAPS = 32'hA300_0000
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) sreg <= SEED;
    else     sreg <= {1'b0, sreg[W-1:1]} ^ (sreg[0] ? TAPS : '0);
  end

  assign word_o = sreg;
endmodule

// File: rtl/rng_timer.sv
module rng_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              wr_ok, rd_ok;

  assign full_o = (level_o == LVL_W'(DEPTH));
  assign wr_ok  = push_i && !full_o && !clr_i;
  assign rd_ok  = pop_i && (level_o != '0) && !clr_i;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata_i;
    if (pop_i) rdata_o   <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wptr    <= '0;
      rptr    <= '0;
      level_o <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      level_o <= level_o + LVL_W'(wr_ok) - LVL_W'(rd_ok);
    end
  end
endmodule

// File: rtl/rng_refill_seq.sv
module rng_refill_seq
  import rng_seq_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          DEPTH        = 8,
  parameter int          STARTUP_TEST = 16,
  parameter int          CNT_W        = 24,
  parameter int          DIV_W        = 4,
  parameter int          NB_W         = 4,
  parameter int          THR_W        = 3,
  parameter logic [31:0] LFSR_SEED    = 32'h1ACE_B00C,
  localparam int         LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              soft_rst_i,
  input  logic              bypass_i,
  input  logic [NB_W-1:0]   nblk_i,
  input  logic [DIV_W-1:0]  clkdiv_i,
  input  logic [CNT_W-1:0]  init_wait_i,
  input  logic [CNT_W-1:0]  off_tmo_i,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [2:0]        state_o
);
  localparam int CMP_W = ((THR_W + 3) > LVL_W) ? (THR_W + 3) : LVL_W;

  seq_state_e        st, st_n;
  logic              en_q;
  logic [2:0]        qcnt, qcnt_n;
  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              fifo_clr, push, full;
  logic [DATA_W-1:0] src_word;

  logic [CNT_W-1:0] div1, nbx, fill_len, su_len, off_len;
  logic [CMP_W-1:0] mark, lvl_after;
  logic             refill;

  rng_lfsr #(.W(DATA_W), .SEED(DATA_W'(LFSR_SEED))) u_src (
    .clk(clk), .rst(rst), .word_o(src_word)
  );

  rng_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
  );

  rng_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr_i(fifo_clr), .push_i(push),
    .wdata_i(src_word), .pop_i(pop_i), .rdata_o(pop_data_o),
    .level_o(level_o), .full_o(full)
  );

  // interval lengths
  always_comb begin
    div1     = CNT_W'(clkdiv_i) + 1'b1;
    nbx      = (nblk_i == '0) ? CNT_W'(1) : CNT_W'(nblk_i);
    fill_len = bypass_i ? (div1 << 5) : ((div1 * nbx) << 7);
    su_len   = init_wait_i + CNT_W'(STARTUP_TEST);
    off_len  = (off_tmo_i == '0) ? CNT_W'(1) : off_tmo_i;
  end

  // low-water mark test on the level left by this pop
  always_comb begin
    mark      = (CMP_W'(thresh_i) + 1'b1) << 2;
    lvl_after = CMP_W'(level_o) - CMP_W'(level_o != '0);
    refill    = pop_i && (lvl_after < mark);
  end

  assign push = (st == ST_FILL) && (qcnt != '0) && !full && en_i && !soft_rst_i;

  always_comb begin
    st_n     = st;
    qcnt_n   = qcnt;
    t_load   = 1'b0;
    t_val    = '0;
    fifo_clr = 1'b0;
    if (soft_rst_i) begin
      fifo_clr = 1'b1;
      st_n     = ST_RESET;
      qcnt_n   = '0;
    end else if (!en_i) begin
      st_n   = ST_RESET;
      qcnt_n = '0;
    end else begin
      case (st)
        ST_RESET: if (!en_q) begin
          st_n   = ST_STARTUP;
          t_load = 1'b1;
          t_val  = su_len - 1'b1;
        end
        ST_STARTUP: if (t_zero) begin
          st_n   = ST_FILL;
          qcnt_n = '0;
          t_load = 1'b1;
          t_val  = fill_len - 1'b1;
        end
        ST_FILL: begin
          if (t_zero) begin
            qcnt_n = bypass_i ? 3'd1 : 3'd4;
            t_load = 1'b1;
            t_val  = fill_len - 1'b1;
          end else if (full) begin
            qcnt_n = '0;
            st_n   = ST_IDLE_ON;
            t_load = 1'b1;
            t_val  = off_len - 1'b1;
          end else if (qcnt != '0) begin
            qcnt_n = qcnt - 1'b1;
          end
        end
        ST_IDLE_ON: begin
          if (refill) begin
            st_n   = ST_FILL;
            t_load = 1'b1;
            t_val  = fill_len - 1'b1;
          end else if (t_zero) begin
            st_n = ST_IDLE_OFF;
          end
        end
        ST_IDLE_OFF: if (refill) begin
          st_n   = ST_STARTUP;
          t_load = 1'b1;
          t_val  = su_len - 1'b1;
        end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_RESET;
      qcnt <= '0;
      en_q <= 1'b0;
    end else begin
      st   <= st_n;
      qcnt <= qcnt_n;
      en_q <= en_i;
    end
  end

  assign state_o = st;
endmodule

// File: rtl/rng_refill_seq_chk.sv
module rng_refill_seq_chk
  import rng_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             soft_rst_i,
  input logic             pop_i,
  input logic [LVL_W-1:0] level_o,
  input logic [2:0]       state_o
);
  a_r5_level_bound: assert property (@(posedge clk) disable iff (rst)
    level_o <= LVL_W'(DEPTH));

  a_r9_level_step: assert property (@(posedge clk) disable iff (rst)
    !soft_rst_i |=> ({1'b0, level_o} <= {1'b0, $past(level_o)} + 1'b1) &&
                    ({1'b0, level_o} + 1'b1 >= {1'b0, $past(level_o)}));

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (level_o == '0) && (state_o == ST_RESET));

  a_r11_disable: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> state_o == ST_RESET);

  a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop_i && (level_o == '0) && (state_o != ST_FILL) |=> level_o == '0);

  a_r6_idle_off_hold: assert property (@(posedge clk) disable iff (rst)
    en_i && !soft_rst_i && !pop_i && (state_o == ST_IDLE_OFF) |=> state_o == ST_IDLE_OFF);

  a_r7_fill_only_rise: assert property (@(posedge clk) disable iff (rst)
    (state_o != ST_FILL) |=> level_o <= $past(level_o));

  a_r1_no_error_code: assert property (@(posedge clk) disable iff (rst)
    state_o != ST_ERROR);
endmodule

bind rng_refill_seq rng_refill_seq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .soft_rst_i(soft_rst_i), .pop_i(pop_i),
  .level_o(level_o), .state_o(state_o)
);

// File: tb/test_rng_refill_seq.sv
module test_rng_refill_seq;
  localparam int DEPTH = 8;
  localparam int SUT   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0, soft_rst_i = 1'b0, bypass_i = 1'b1, pop_i = 1'b0;
  logic [3:0]  nblk_i = 4'd1, clkdiv_i = 4'd1;
  logic [23:0] init_wait_i = 24'd5, off_tmo_i = 24'd20;
  logic [2:0]  thresh_i = 3'd0;
  logic [31:0] pop_data_o;
  logic [3:0]  level_o;
  logic [2:0]  state_o;

  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 0;
  logic [31:0] d0;

  rng_refill_seq i_rng_refill_seq (
    .clk(clk), .rst(rst), .en_i(en_i), .soft_rst_i(soft_rst_i), .bypass_i(bypass_i),
    .nblk_i(nblk_i), .clkdiv_i(clkdiv_i), .init_wait_i(init_wait_i),
    .off_tmo_i(off_tmo_i), .thresh_i(thresh_i), .pop_i(pop_i),
    .pop_data_o(pop_data_o), .level_o(level_o), .state_o(state_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: R1 run hung act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pop1();
    pop_i = 1'b1;
    step();
    pop_i = 1'b0;
  endtask

  // counts observed cycles in state s (starting at current negedge)
  task automatic dwell(input int s, output int n);
    n = 0;
    while (state_o == 3'(s) && n < 100000) begin
      n++;
      step();
    end
  endtask

  task automatic wait_for(input int s, input int lim);
    int n = 0;
    while (state_o != 3'(s) && n < lim) begin
      n++;
      step();
      if (level_o > 4'(DEPTH)) chk(0, "R5 level bound", level_o, DEPTH);
    end
  endtask

  // measure word arrival cycles from fill entry (t = 0 at current negedge)
  task automatic measure_fill(input int nwords, input int d, input bit byp, input string req);
    int t = 0;
    int k = 0;
    int prev = level_o;
    while (k < nwords && t < 20000) begin
      step();
      t++;
      if (int'(level_o) != prev) begin
        int ex;
        ex = byp ? (k + 1) * d + 1 : (k / 4 + 1) * d + 1 + (k % 4);
        chk(t == ex, req, t, ex);
        chk(int'(level_o) == prev + 1, {req, " step"}, level_o, prev + 1);
        prev = level_o;
        k++;
      end
    end
    chk(k == nwords, {req, " count"}, k, nwords);
  endtask

  initial begin
    int n;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(level_o == 4'd0, "R1 reset level", level_o, 0);

    // ---- bypass configuration, divider 1 -> D = 64
    en_i = 1'b1;
    step();
    chk(state_o == 3'd1, "R2 startup entry", state_o, 1);
    dwell(1, n);
    chk(n == 5 + SUT, "R2 startup length", n, 5 + SUT);
    chk(state_o == 3'd4, "R2 then fill", state_o, 4);
    measure_fill(8, 64, 1'b1, "R3 bypass cadence");
    wait_for(2, 10);
    chk(state_o == 3'd2, "R5 full -> idle-on", state_o, 2);
    dwell(2, n);
    chk(n == 20, "R6 idle-on timeout", n, 20);
    repeat (50) step();
    chk(state_o == 3'd3, "R6 idle-off holds", state_o, 3);
    chk(level_o == 4'd8, "R6 level kept", level_o, 8);

    // pops with mark = 4
    pop1();
    d0 = pop_data_o;
    chk(level_o == 4'd7, "R7 pop level", level_o, 7);
    chk(state_o == 3'd3, "R7 above mark", state_o, 3);
    pop1(); pop1(); pop1();
    chk(level_o == 4'd4 && state_o == 3'd3, "R7 at mark no refill", state_o, 3);
    pop1();
    chk(state_o == 3'd1, "R7 idle-off -> startup", state_o, 1);
    pop1(); pop1(); pop1();
    chk(level_o == 4'd0, "R7 drained", level_o, 0);
    pop1();
    chk(level_o == 4'd0, "R8 empty pop level", level_o, 0);
    chk(pop_data_o == d0, "R8 empty pop word", pop_data_o, d0);

    // simultaneous write and pop
    wait_for(4, 100);
    for (int t = 0; t < 128; t++) step();
    chk(level_o == 4'd1, "R3 first word", level_o, 1);
    pop_i = 1'b1;
    step();
    pop_i = 1'b0;
    chk(level_o == 4'd1, "R9 push+pop same edge", level_o, 1);
    for (int t = 129; t < 64 * 3 + 1; t++) step();
    chk(level_o == 4'd2, "R9 next word", level_o, 2);

    // soft reset with enable held
    soft_rst_i = 1'b1;
    step();
    soft_rst_i = 1'b0;
    chk(state_o == 3'd0, "R10 soft reset state", state_o, 0);
    chk(level_o == 4'd0, "R10 soft reset level", level_o, 0);
    repeat (30) step();
    chk(state_o == 3'd0, "R10 stays disabled", state_o, 0);

    // ---- conditioned configuration, NB = 1, divider 0 -> D = 128
    en_i = 1'b0; bypass_i = 1'b0; nblk_i = 4'd1; clkdiv_i = 4'd0; off_tmo_i = 24'd2000;
    step();
    en_i = 1'b1;
    step();
    chk(state_o == 3'd1, "R2 restart", state_o, 1);
    dwell(1, n);
    chk(n == 5 + SUT, "R2 startup length 2", n, 5 + SUT);
    measure_fill(8, 128, 1'b0, "R4 conditioned cadence");
    wait_for(2, 10);
    chk(state_o == 3'd2 && level_o == 4'd8, "R5 idle-on full", level_o, 8);
    pop1(); pop1(); pop1(); pop1();
    chk(state_o == 3'd2, "R7 idle-on above mark", state_o, 2);
    pop1();
    chk(state_o == 3'd4, "R7 idle-on -> fill", state_o, 4);
    chk(level_o == 4'd3, "R7 level 3", level_o, 3);
    wait_for(2, 2000);
    chk(state_o == 3'd2, "R5 overrun -> idle-on", state_o, 2);
    chk(level_o == 4'd8, "R5 discard leftover", level_o, 8);

    // disable keeps FIFO
    en_i = 1'b0;
    step();
    chk(state_o == 3'd0, "R11 disable state", state_o, 0);
    chk(level_o == 4'd8, "R11 level kept", level_o, 8);

    // re-enable full, threshold 1 -> mark 8
    en_i = 1'b1;
    wait_for(2, 1000);
    chk(state_o == 3'd2, "R5 full re-enable", state_o, 2);
    thresh_i = 3'd1;
    pop1();
    chk(state_o == 3'd4, "R7 mark 8 refill", state_o, 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule